// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block is a centralized hardware barrier shared by a fixed group of requesters (up to sixteen, set by a parameter). A requester signals that it has reached the barrier with a one-cycle arrive strobe. It is then held until the programmed number of participants have all arrived. At that point every held requester gets a one-cycle release pulse in the same cycle, and all of them may go on.

Internally the unit keeps one arrival counter, updated by fetch-and-increment, and a global release flag. Each requester has a private sense bit. The sense bit flips when the requester's arrival is accepted. The requester that completes the count returns the counter to zero and copies its own sense into the global flag. Every held requester whose sense matches the flag is then freed. The flag is never cleared, so episodes can run back to back. A requester that re-enters at once holds on the opposite sense value and cannot disturb the episode that is just ending.

Arrivals that land in the same cycle wait in a per-requester pending bit. A round-robin arbiter hands out one increment per cycle. The participant total can be reprogrammed, but only while no episode is in progress.

Top module: `barrier_unit`

## Requirements
- R1: After reset, release_o, waiting_o and err_o are all zero, the participant total equals NUM_REQ, every sense bit is 1 and the global flag is 1.
- R2: An accepted arrive strobe sampled at clock edge e makes the requester pending. A round-robin arbiter grants exactly one pending requester per edge. The granted requester is counted and shows waiting_o=1 after that edge, so a lone arrival is counted at edge e+1.
- R3: No requester receives release_o before the increment that brings the count to the programmed total.
- R4: When the increment at edge G reaches the total, every waiting requester, the completing one included, is released at edge G+1. At that edge release_o pulses high for one cycle and waiting_o clears, for all of them together.
- R5: On completion the counter returns to zero and the next episode can start at once. A requester that re-arrives in the first cycle after its release is held until the new episode completes.
- R6: An arrive strobe from a requester that is already pending or waiting produces a one-cycle err_o pulse for that requester after the sampling edge. The strobe is otherwise ignored: it is not counted and the sense bit is not flipped.
- R7: A write of the total (total_we_i=1) takes effect only if three conditions hold: the counter is zero, no increment happens in that cycle, and the value lies in 1..NUM_REQ. Otherwise the write is ignored.
- R8: The counter changes by at most one increment per cycle, and only on a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | NUM_REQ | Per-requester one-cycle arrive strobe |
| total_we_i | input | 1 | Write strobe for the participant total |
| total_i | input | CNT_W | New participant total |
| release_o | output | NUM_REQ | Registered one-cycle release pulse per requester |
| waiting_o | output | NUM_REQ | Requester is counted and held in the barrier |
| err_o | output | NUM_REQ | Registered one-cycle pulse for a duplicate arrive |

## Verification
A wrong counter value or a wrong participant total shows as a release pulse that comes one or more grants too early, or that never comes. The bench therefore models the arbiter's one-grant-per-cycle queue arithmetically and predicts the exact release cycle of each episode. A stale sense bit or global flag shows in the next episode, at the latest. In that episode an immediately re-entering requester would be freed at once instead of being held with the others. A counted duplicate arrive would bring the release forward by one arrival, in the same episode.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  localparam int MAX_REQ = 16;

  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int index_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/barrier_rr_arb.sv
module barrier_rr_arb #(
  parameter int N = 4,
  localparam int IW = barrier_pkg::index_width(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          gnt_v,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int c;
    gnt     = '0;
    gnt_v   = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      c = (int'(ptr_q) + k) % N;
      if (!gnt_v && req[c]) begin
        gnt_v    = 1'b1;
        gnt[c]   = 1'b1;
        gnt_idx  = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (gnt_v) begin
      ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R8
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0); // R2
endmodule

// File: rtl/barrier_fai.sv
module barrier_fai #(
  parameter int N  = 4,
  parameter int CW = barrier_pkg::count_width(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          inc_sense_i,
  input  logic          total_we_i,
  input  logic [CW-1:0] total_i,
  output logic          flag_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] total_q;
  logic [CW-1:0] cnt_nxt;
  logic          flag_q;
  logic          done;
  logic          total_ok;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign done     = inc_i && (cnt_nxt == total_q);
  assign total_ok = total_we_i && (cnt_q == '0) && !inc_i &&
                    (total_i != '0) && (total_i <= CW'(N));
  assign flag_o   = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      total_q <= CW'(N);
      flag_q  <= 1'b1;
    end else begin
      if (inc_i) begin
        cnt_q <= done ? '0 : cnt_nxt;
      end
      if (done) begin
        flag_q <= inc_sense_i;
      end
      if (total_ok) begin
        total_q <= total_i;
      end
    end
  end

  AST_CNT_BELOW_TOTAL: assert property (@(posedge clk) disable iff (rst) cnt_q < total_q); // R3
  AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (rst) (cnt_q != '0) |=> $stable(total_q)); // R7
  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(flag_q) |-> $past(done)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) !$stable(cnt_q) |-> $past(inc_i)); // R8
endmodule

// File: rtl/barrier_lane.sv
module barrier_lane (
  input  logic clk,
  input  logic rst,
  input  logic arrive_i,
  input  logic grant_i,
  input  logic flag_i,
  output logic pend_o,
  output logic sense_o,
  output logic wait_o,
  output logic rel_o,
  output logic err_o
);
  logic pend_q;
  logic sense_q;
  logic wait_q;
  logic rel_q;
  logic err_q;
  logic busy;
  logic accept;
  logic dup;
  logic free_now;

  assign busy     = pend_q | wait_q;
  assign accept   = arrive_i & ~busy;
  assign dup      = arrive_i & busy;
  assign free_now = wait_q & (flag_i == sense_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      sense_q <= 1'b1;
      wait_q  <= 1'b0;
      rel_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        sense_q <= ~sense_q;
        pend_q  <= 1'b1;
      end else if (grant_i) begin
        pend_q  <= 1'b0;
      end
      if (grant_i) begin
        wait_q <= 1'b1;
      end else if (free_now) begin
        wait_q <= 1'b0;
      end
      rel_q <= free_now;
      err_q <= dup;
    end
  end

  assign pend_o  = pend_q;
  assign sense_o = sense_q;
  assign wait_o  = wait_q;
  assign rel_o   = rel_q;
  assign err_o   = err_q;

  AST_REL_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst) rel_q |-> $past(wait_q)); // R4
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst) !(pend_q && wait_q)); // R6
  AST_DUP_KEEPS_SENSE: assert property (@(posedge clk) disable iff (rst) err_q |-> $stable(sense_q)); // R6
endmodule

// File: rtl/barrier_unit.sv
module barrier_unit #(
  parameter int NUM_REQ = 4,
  localparam int CNT_W = barrier_pkg::count_width(NUM_REQ),
  localparam int IDX_W = barrier_pkg::index_width(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] arrive_i,
  input  logic               total_we_i,
  input  logic [CNT_W-1:0]   total_i,
  output logic [NUM_REQ-1:0] release_o,
  output logic [NUM_REQ-1:0] waiting_o,
  output logic [NUM_REQ-1:0] err_o
);
  logic [NUM_REQ-1:0] pend;
  logic [NUM_REQ-1:0] sense;
  logic [NUM_REQ-1:0] gnt;
  logic               gnt_v;
  logic [IDX_W-1:0]   gnt_idx;
  logic               flag;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_lane
    barrier_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .arrive_i (arrive_i[i]),
      .grant_i  (gnt[i]),
      .flag_i   (flag),
      .pend_o   (pend[i]),
      .sense_o  (sense[i]),
      .wait_o   (waiting_o[i]),
      .rel_o    (release_o[i]),
      .err_o    (err_o[i])
    );
  end

  barrier_rr_arb #(.N(NUM_REQ)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (pend),
    .gnt     (gnt),
    .gnt_v   (gnt_v),
    .gnt_idx (gnt_idx)
  );

  barrier_fai #(.N(NUM_REQ), .CW(CNT_W)) u_fai (
    .clk         (clk),
    .rst         (rst),
    .inc_i       (gnt_v),
    .inc_sense_i (sense[gnt_idx]),
    .total_we_i  (total_we_i),
    .total_i     (total_i),
    .flag_o      (flag)
  );

  AST_REL_GROUP: assert property (@(posedge clk) disable iff (rst) (release_o & waiting_o) == '0); // R4
endmodule

// File: tb/tb_barrier_unit.sv
module tb_barrier_unit;
  localparam int N = 4;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  arrive = '0;
  logic          total_we = 1'b0;
  logic [CW-1:0] total_in = '0;
  logic [N-1:0]  release_o;
  logic [N-1:0]  waiting_o;
  logic [N-1:0]  err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  barrier_unit #(.NUM_REQ(N)) dut (
    .clk        (clk),
    .rst        (rst),
    .arrive_i   (arrive),
    .total_we_i (total_we),
    .total_i    (total_in),
    .release_o  (release_o),
    .waiting_o  (waiting_o),
    .err_o      (err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); arrive = m;
    @(negedge clk); arrive = '0;
  endtask

  task automatic write_total(input int v);
    @(negedge clk); total_we = 1'b1; total_in = CW'(v);
    @(negedge clk); total_we = 1'b0;
  endtask

  function automatic logic [N-1:0] bits_at(input int t, input int d0, input int d1,
                                           input int d2, input int d3);
    logic [N-1:0] b;
    b[0] = (t == d0); b[1] = (t == d1); b[2] = (t == d2); b[3] = (t == d3);
    return b;
  endfunction

  // Full-group episode with a cycle model of one grant per edge (R2, R3, R4, R5)
  task automatic run_episode(input int d0, input int d1, input int d2, input int d3);
    int p = 0;
    int granted = 0;
    int g = -1;
    logic [N-1:0] a;
    logic [N-1:0] exp;
    @(negedge clk); arrive = bits_at(0, d0, d1, d2, d3);
    for (int t = 0; t < 200; t++) begin
      a = arrive;
      @(posedge clk);
      if (p > 0) begin
        p--; granted++;
        if (granted == N) g = t;
      end
      p += $countones(a);
      @(negedge clk);
      exp = (g >= 0 && t == g + 1) ? '1 : '0;
      if (exp == '0) check(release_o == exp, "R3 early release", release_o, exp);
      else           check(release_o == exp, "R4 group release", release_o, exp);
      if (exp != '0) begin
        check(waiting_o == '0, "R4 waiting cleared", waiting_o, 0);
        arrive = '0;
        break;
      end
      arrive = bits_at(t + 1, d0, d1, d2, d3);
    end
    arrive = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(release_o == '0, "R1 release reset", release_o, 0);
    check(waiting_o == '0, "R1 waiting reset", waiting_o, 0);
    check(err_o == '0, "R1 err reset", err_o, 0);
    rst = 1'b0;

    // R1 default total of N, R2 lone arrivals
    run_episode(0, 3, 6, 9);
    // R2 simultaneous arrivals serialized
    run_episode(0, 0, 0, 0);
    // R5 back-to-back episodes, requester 0 re-enters immediately
    for (int ep = 1; ep <= 3; ep++) begin
      run_episode(0, (1 * ep + 2) % 5, (2 * ep + 1) % 6, 3 * ep);
    end

    // R6 duplicate arrive while waiting
    pulse(4'b0001);
    pulse(4'b0010);
    @(negedge clk);
    check(waiting_o == 4'b0011, "R2 waiting status", waiting_o, 4'b0011);
    pulse(4'b0010);
    check(err_o == 4'b0010, "R6 err pulse", err_o, 4'b0010);
    @(negedge clk);
    check(err_o == '0, "R6 err one cycle", err_o, 0);
    pulse(4'b0100);
    @(negedge clk);
    check(waiting_o == 4'b0111, "R6 duplicate not counted", waiting_o, 4'b0111);
    check(release_o == '0, "R6 no early release", release_o, 0);
    pulse(4'b1000);
    @(negedge clk);
    check(release_o == '0, "R3 release timing", release_o, 0);
    @(negedge clk);
    check(release_o == 4'b1111, "R4 release after dup", release_o, 4'b1111);

    // R7 accepted write while idle, ignored write mid-episode
    write_total(2);
    pulse(4'b0001);
    write_total(3);
    pulse(4'b0010);
    @(negedge clk);
    check(release_o == '0, "R7 pair timing", release_o, 0);
    @(negedge clk);
    check(release_o == 4'b0011, "R7 total 2 kept", release_o, 4'b0011);

    // R7 out-of-range values ignored
    write_total(0);
    write_total(5);
    pulse(4'b0001);
    pulse(4'b0010);
    @(negedge clk);
    check(release_o == '0, "R7 pair timing 2", release_o, 0);
    @(negedge clk);
    check(release_o == 4'b0011, "R7 invalid totals ignored", release_o, 4'b0011);

    write_total(4);
    run_episode(2, 0, 1, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule